// File: doc/BRIEF.md
# Memory controller chip-select decoder

This block holds the configuration registers of an external memory controller and turns every incoming memory address into a one-hot chip-select vector. Software reaches the registers over a simple 32-bit register bus with a write strobe and a combinational read port. There is a general status word, a read-only copy of the power-on strap pins, a shared base-address mask, and a configuration/timing register pair for each of `NUM_CS` chip selects.

Each chip select compares the address bits from bit 22 upward, under the shared mask, against the 8-bit select field in the top byte of its configuration word. Enabled selects that match compete by index, and the lowest one drives the output. After reset only chip select 0 is enabled. It takes its memory type and bus width from the strap pins, and with a zero mask it claims every address, so the system can boot from it before any register is written.

Top module: `memctl_csdec`

## Requirements
- R1: On reset the status register, the mask register and the configuration and timing registers of chip selects 1 to NUM_CS-1 read zero.
- R2: On reset chip select 0's configuration reads with bit 0 (enable) = 1, bits [2:1] = strap[1:0] (bus width), bits [6:4] = {0, strap[3:2]} (memory type), and all other bits 0.
- R3: On reset chip select 0's timing word depends on strap[3:2]. The type codes are 0 = asynchronous, 1 = SDRAM, 2 = SSRAM and 3 = synchronous, and they give 0x0FFF_FFFF, 0x07FF_FFFF, 0x0000_00FF and 0x0000_0FFF in that order.
- R4: Offset 0x04 reads {28'b0, strap}, with strap captured during reset. Writes to it have no effect.
- R5: The mask register at offset 0x08 keeps only written bits [7:0]. Bits [31:8] read zero.
- R6: Chip select i has its configuration at offset 0x10 + 8*i and its timing at 0x14 + 8*i. Offset bit 2 selects timing (1) or configuration (0). Both are full 32-bit read/write.
- R7: Chip select i matches address A when its configuration bit 0 is 1 and (A & (mask << 22)) == (cfg[31:24] << 22), computed in 32 bits.
- R8: When several chip selects match, only the lowest-numbered one is driven. The output is one-hot, or zero when none match.
- R9: A mask write changes the chip-select output from the clock edge that accepts it.
- R10: Reads from undefined offsets return zero. This covers 0x0C, any offset with bits [1:0] non-zero, and any offset at or above 0x10 + 8*NUM_CS. Writes to those offsets change no register.
- R11: The status register at offset 0x00 stores and returns all 32 written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_i | input | 4 | Power-on strap pins: [3:2] memory type, [1:0] bus width |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| mem_addr_i | input | 32 | Memory access address to decode |
| cs_sel_o | output | 8 | One-hot chip-select output |

## Verification
A wrong stored bit in a configuration word, or in the mask, shows up in the same cycle on `cs_sel_o` for the address slices it affects. The bench sweeps all 1024 values of address bits [31:22] under two masks so that every such slice is exercised. A wrong reset image of chip select 0 shows on the first read after reset and, through the always-matching zero mask, on the select output. A broken priority chain shows up as two active bits, or as the wrong bit, whenever two enabled selects share a select field.

// File: rtl/memctl_csdec_pkg.sv
package memctl_csdec_pkg;

  localparam int unsigned DW        = 32;
  localparam int unsigned MASK_W    = 8;
  localparam int unsigned MATCH_LSB = 22;

  typedef enum logic [1:0] {
    MT_ASYNC = 2'd0,
    MT_SDRAM = 2'd1,
    MT_SSRAM = 2'd2,
    MT_SYNC  = 2'd3
  } mem_type_e;

  // Configuration word seen by chip select 0 straight out of reset.
  function automatic logic [DW-1:0] cfg_from_strap(input logic [3:0] s);
    logic [DW-1:0] c;
    c      = '0;
    c[0]   = 1'b1;
    c[2:1] = s[1:0];
    c[6:4] = {1'b0, s[3:2]};
    return c;
  endfunction

  // Default timing word for each memory type.
  function automatic logic [DW-1:0] tmg_default(input mem_type_e t);
    case (t)
      MT_ASYNC: return 32'h0FFF_FFFF;
      MT_SDRAM: return 32'h07FF_FFFF;
      MT_SSRAM: return 32'h0000_00FF;
      default:  return 32'h0000_0FFF;
    endcase
  endfunction

  // Masked compare of the upper address bits against a select field.
  function automatic logic cs_match(input logic [DW-1:0] addr,
                                    input logic [MASK_W-1:0] mask,
                                    input logic [DW-1:0] cfg);
    logic [DW-1:0] m;
    logic [DW-1:0] s;
    m = {{(DW-MASK_W){1'b0}}, mask} << MATCH_LSB;
    s = {{(DW-MASK_W){1'b0}}, cfg[DW-1:DW-MASK_W]} << MATCH_LSB;
    return cfg[0] && ((addr & m) == s);
  endfunction

endpackage

// File: rtl/memctl_csdec_regs.sv
module memctl_csdec_regs
  import memctl_csdec_pkg::*;
#(
  parameter int unsigned NUM_CS = 8,
  parameter int unsigned AW     = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [3:0]               strap_i,
  input  logic                     we_i,
  input  logic [AW-1:0]            addr_i,
  input  logic [DW-1:0]            wdata_i,
  output logic [DW-1:0]            rdata_o,
  output logic [DW-1:0]            status_o,
  output logic [3:0]               strap_q_o,
  output logic [MASK_W-1:0]        mask_o,
  output logic [NUM_CS-1:0][DW-1:0] cfg_o,
  output logic [NUM_CS-1:0][DW-1:0] tmg_o
);
  localparam int unsigned IDX_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;
  localparam int unsigned OFF_ST  = 0;
  localparam int unsigned OFF_STR = 4;
  localparam int unsigned OFF_MSK = 8;
  localparam int unsigned CS_BASE = 16;
  localparam int unsigned CS_END  = CS_BASE + 8 * NUM_CS;

  logic [AW-1:0]    rel;
  logic [IDX_W-1:0] cs_idx;
  logic             aligned, in_cs, is_tmg;
  logic             hit_st, hit_str, hit_msk;

  always_comb begin
    aligned = (addr_i[1:0] == 2'b00);
    rel     = addr_i - AW'(CS_BASE);
    cs_idx  = IDX_W'(rel >> 3);
    is_tmg  = rel[2];
    in_cs   = aligned && (int'(addr_i) >= CS_BASE) && (int'(addr_i) < CS_END);
    hit_st  = (int'(addr_i) == OFF_ST);
    hit_str = (int'(addr_i) == OFF_STR);
    hit_msk = (int'(addr_i) == OFF_MSK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_o  <= '0;
      mask_o    <= '0;
      strap_q_o <= strap_i;
      for (int i = 0; i < NUM_CS; i++) begin
        cfg_o[i] <= (i == 0) ? cfg_from_strap(strap_i) : '0;
        tmg_o[i] <= (i == 0) ? tmg_default(mem_type_e'(strap_i[3:2])) : '0;
      end
    end else if (we_i) begin
      if (hit_st)  status_o <= wdata_i;
      if (hit_msk) mask_o   <= wdata_i[MASK_W-1:0];
      if (in_cs) begin
        if (is_tmg) tmg_o[cs_idx] <= wdata_i;
        else        cfg_o[cs_idx] <= wdata_i;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit_st)       rdata_o = status_o;
    else if (hit_str) rdata_o = {{(DW-4){1'b0}}, strap_q_o};
    else if (hit_msk) rdata_o = {{(DW-MASK_W){1'b0}}, mask_o};
    else if (in_cs)   rdata_o = is_tmg ? tmg_o[cs_idx] : cfg_o[cs_idx];
  end

endmodule

// File: rtl/memctl_csdec_match.sv
module memctl_csdec_match
  import memctl_csdec_pkg::*;
#(
  parameter int unsigned NUM_CS = 8
) (
  input  logic [DW-1:0]             addr_i,
  input  logic [MASK_W-1:0]         mask_i,
  input  logic [NUM_CS-1:0][DW-1:0] cfg_i,
  output logic [NUM_CS-1:0]         hit_o
);
  for (genvar g = 0; g < NUM_CS; g++) begin : g_cmp
    assign hit_o[g] = cs_match(addr_i, mask_i, cfg_i[g]);
  end
endmodule

// File: rtl/memctl_csdec_prio.sv
module memctl_csdec_prio #(
  parameter int unsigned NUM_CS = 8
) (
  input  logic [NUM_CS-1:0] hit_i,
  output logic [NUM_CS-1:0] sel_o
);
  logic taken;
  always_comb begin
    sel_o = '0;
    taken = 1'b0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (hit_i[i] && !taken) begin
        sel_o[i] = 1'b1;
        taken    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/memctl_csdec.sv
module memctl_csdec
  import memctl_csdec_pkg::*;
#(
  parameter int unsigned NUM_CS = 8,
  parameter int unsigned REG_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        strap_i,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic [31:0]       mem_addr_i,
  output logic [NUM_CS-1:0] cs_sel_o
);
  logic [DW-1:0]             status_q;
  logic [3:0]                strap_q;
  logic [MASK_W-1:0]         mask_q;
  logic [NUM_CS-1:0][DW-1:0] cfg_q;
  logic [NUM_CS-1:0][DW-1:0] tmg_q;
  logic [NUM_CS-1:0]         cs_hit;

  memctl_csdec_regs #(.NUM_CS(NUM_CS), .AW(REG_AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .strap_i(strap_i),
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .status_o(status_q), .strap_q_o(strap_q),
    .mask_o(mask_q), .cfg_o(cfg_q), .tmg_o(tmg_q)
  );

  memctl_csdec_match #(.NUM_CS(NUM_CS)) u_match (
    .addr_i(mem_addr_i), .mask_i(mask_q), .cfg_i(cfg_q), .hit_o(cs_hit)
  );

  memctl_csdec_prio #(.NUM_CS(NUM_CS)) u_prio (
    .hit_i(cs_hit), .sel_o(cs_sel_o)
  );
endmodule

// File: rtl/memctl_csdec_chk.sv
module memctl_csdec_chk #(
  parameter int unsigned NUM_CS = 8,
  parameter int unsigned REG_AW = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we_i,
  input logic [REG_AW-1:0] reg_addr_i,
  input logic [31:0]       reg_wdata_i,
  input logic [31:0]       reg_rdata_o,
  input logic [NUM_CS-1:0] cs_sel_o,
  input logic [NUM_CS-1:0] cs_hit,
  input logic [7:0]        mask_q,
  input logic [31:0]       status_q,
  input logic [3:0]        strap_q
);
  logic undef_off;
  assign undef_off = (reg_addr_i[1:0] != 2'b00) || (int'(reg_addr_i) == 12) ||
                     (int'(reg_addr_i) >= 16 + 8 * NUM_CS);

  // R8
  onehot_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_sel_o));

  // R8
  sel_from_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cs_sel_o & cs_hit) == cs_sel_o) && ((cs_hit != '0) == (cs_sel_o != '0)));

  // R9
  mask_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we_i && int'(reg_addr_i) == 8) |=> (mask_q == $past(reg_wdata_i[7:0])));

  // R11
  status_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we_i && int'(reg_addr_i) == 0) |=> (status_q == $past(reg_wdata_i)));

  // R4
  strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(strap_q));

  // R10
  undef_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    undef_off |-> (reg_rdata_o == 32'h0));
endmodule

bind memctl_csdec memctl_csdec_chk #(.NUM_CS(NUM_CS), .REG_AW(REG_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .cs_sel_o(cs_sel_o),
  .cs_hit(cs_hit), .mask_q(mask_q), .status_q(status_q), .strap_q(strap_q)
);

// File: tb/tb_memctl_csdec.sv
module tb_memctl_csdec;
  localparam int NCS = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  strap = 4'h0;
  logic        we = 1'b0;
  logic [7:0]  addr = 8'h0;
  logic [31:0] wdata = 32'h0;
  logic [31:0] rdata;
  logic [31:0] maddr = 32'h0;
  logic [NCS-1:0] sel;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [31:0] m_cfg [NCS];
  logic [31:0] m_tmg [NCS];
  logic [7:0]  m_mask;
  logic [31:0] m_status;

  always #4 clk = ~clk;

  memctl_csdec dut (
    .clk(clk), .rst_n(rst_n), .strap_i(strap), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .mem_addr_i(maddr), .cs_sel_o(sel)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [3:0] s);
    @(negedge clk);
    strap = s; rst_n = 1'b0; we = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    check(req, rdata, exp);
  endtask

  function automatic logic [31:0] exp_tmg0(input logic [1:0] t);
    if (t == 2'd0) return 32'h0FFF_FFFF;
    if (t == 2'd1) return 32'h07FF_FFFF;
    if (t == 2'd2) return 32'h0000_00FF;
    return 32'h0000_0FFF;
  endfunction

  function automatic logic [NCS-1:0] exp_sel(input logic [31:0] a);
    logic [9:0] top;
    top = a[31:22];
    for (int i = 0; i < NCS; i++) begin
      if (m_cfg[i][0] && ((top & {2'b00, m_mask}) == {2'b00, m_cfg[i][31:24]}))
        return NCS'(1) << i;
    end
    return '0;
  endfunction

  task automatic sweep(input string req);
    for (int v = 0; v < 1024; v++) begin
      @(negedge clk);
      maddr = (32'(v) << 22) | (32'(v) * 32'h1357);
      #1;
      check(req, 32'(sel), 32'(exp_sel(maddr)));
    end
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    if (!done) $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R2 R3 R4: every strap value
    for (int s = 0; s < 16; s++) begin
      do_reset(4'(s));
      rd_chk("R2 cfg0", 8'h10, {25'b0, 1'b0, 2'(s >> 2), 1'b0, 2'(s & 3), 1'b1});
      rd_chk("R3 tmg0", 8'h14, exp_tmg0(2'(s >> 2)));
      rd_chk("R4 strap", 8'h04, 32'(s));
    end
    // R1: other reset values (strap = 15 still applied)
    rd_chk("R1 status", 8'h00, 32'h0);
    rd_chk("R1 mask", 8'h08, 32'h0);
    for (int i = 1; i < NCS; i++) begin
      rd_chk("R1 cfg", 8'(16 + 8 * i), 32'h0);
      rd_chk("R1 tmg", 8'(20 + 8 * i), 32'h0);
    end
    for (int i = 0; i < NCS; i++) begin
      m_cfg[i] = (i == 0) ? 32'h0000_0037 : 32'h0;
      m_tmg[i] = (i == 0) ? 32'h0000_0FFF : 32'h0;
    end
    m_mask = 8'h0; m_status = 32'h0;
    // R7: zero mask, cs0 claims every address
    @(negedge clk); maddr = 32'hDEAD_BEEF; #1;
    check("R7 boot select", 32'(sel), 32'h1);

    // R4: write to strap register ignored
    wr(8'h04, 32'hFFFF_FFF0);
    rd_chk("R4 strap write ignored", 8'h04, 32'hF);
    // R11
    wr(8'h00, 32'hA5A5_5A5A); m_status = 32'hA5A5_5A5A;
    rd_chk("R11 status", 8'h00, 32'hA5A5_5A5A);
    // R5
    wr(8'h08, 32'hFFFF_FF3C); m_mask = 8'h3C;
    rd_chk("R5 mask", 8'h08, 32'h0000_003C);

    // R6: program every pair
    for (int i = 0; i < NCS; i++) begin
      m_cfg[i] = {8'(i * 37 + 1), 16'h0, 7'h0, (i != 5)};
      m_tmg[i] = 32'h1111_0000 + 32'(i);
    end
    m_cfg[6] = {m_cfg[2][31:24], 23'h0, 1'b1};
    for (int i = 0; i < NCS; i++) begin
      wr(8'(16 + 8 * i), m_cfg[i]);
      wr(8'(20 + 8 * i), m_tmg[i]);
    end
    for (int i = 0; i < NCS; i++) begin
      rd_chk("R6 cfg", 8'(16 + 8 * i), m_cfg[i]);
      rd_chk("R6 tmg", 8'(20 + 8 * i), m_tmg[i]);
    end

    // R9: mask change acts on next cycle
    wr(8'h08, 32'h0000_00FF); m_mask = 8'hFF;
    @(negedge clk); maddr = {2'b00, m_cfg[3][31:24], 22'h1}; #1;
    check("R9 mask immediate", 32'(sel), 32'h08);
    // R7 R8: full sweep, cs6 shares cs2's field, cs5 disabled
    sweep("R7 R8 mask ff");
    @(negedge clk); maddr = {2'b00, m_cfg[2][31:24], 22'h0}; #1;
    check("R8 lowest wins", 32'(sel), 32'h04);
    @(negedge clk); maddr = {2'b11, m_cfg[5][31:24], 22'h0}; #1;
    check("R7 disabled cs", 32'(sel), 32'h0);
    wr(8'h08, 32'h0000_000F); m_mask = 8'h0F;
    sweep("R7 R9 mask 0f");

    // R10: undefined offsets
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h50, 32'hFFFF_FFFF);
    wr(8'h11, 32'hFFFF_FFFF);
    wr(8'hFC, 32'hFFFF_FFFF);
    rd_chk("R10 read 0c", 8'h0C, 32'h0);
    rd_chk("R10 read 50", 8'h50, 32'h0);
    rd_chk("R10 read 15", 8'h15, 32'h0);
    rd_chk("R10 status kept", 8'h00, m_status);
    rd_chk("R10 mask kept", 8'h08, 32'(m_mask));
    for (int i = 0; i < NCS; i++) begin
      rd_chk("R10 cfg kept", 8'(16 + 8 * i), m_cfg[i]);
      rd_chk("R10 tmg kept", 8'(20 + 8 * i), m_tmg[i]);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule